// File: doc/BRIEF.md
# Redundant Load Value Queue

This block lets software issue every load twice and still touch memory only once. The first copy (the original load) records its address in the next free queue slot. The memory response for that load later fills in the slot's value. The second copy (the duplicate load) never reaches memory. It is answered from the slot that the original filled, and its own address is compared with the recorded one. Memory traffic therefore stays at one access per load pair. The value the duplicate receives cannot have been disturbed between the memory read and the copy into the redundant register.

Slots are allocated in arrival order by original loads and are released in the same order by duplicates, so a load and its duplicate always meet in the same slot without any explicit tag. Memory responses return in order and fill the oldest slot that is still waiting. A mismatch between addresses, or a duplicate for which no slot exists, raises a fault flag that stays set until reset.

Top module: `dup_load_queue`

## Requirements
- R1: After reset, `orig_ready` is 1, `dup_ready` is 0, `dup_rsp_valid` is 0 and `fault` is 0.
- R2: Up to DEPTH original loads can be outstanding. While DEPTH slots are in use, `orig_ready` is 0 and further original loads are stalled.
- R3: Memory responses fill slots in the order the original loads arrived. Duplicates are answered in that same order, so the k-th duplicate receives the data of the k-th memory response.
- R4: A duplicate accepted on a clock edge (`dup_req_valid` and `dup_ready` both 1) produces `dup_rsp_valid` = 1 in the following cycle, with `dup_rsp_data` equal to the value recorded in its slot. No response appears in any other cycle.
- R5: While the oldest slot still awaits its memory response, `dup_ready` is 0 and the duplicate is held. It is accepted once the response has been written.
- R6: If an accepted duplicate's address differs from the recorded address, `fault` rises in the next cycle and the recorded value is still returned.
- R7: A duplicate request made while no slot is in use raises `fault` in the next cycle and produces no response.
- R8: Once `fault` is 1 it stays 1 until reset, regardless of further traffic.
- R9: A memory response that arrives while no slot is waiting for data is ignored and does not change any later duplicate's value.
- R10: Releasing a slot through a duplicate makes room at once: after a duplicate is accepted from a full queue, `orig_ready` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orig_req_valid | input | 1 | Original load present |
| orig_req_addr | input | AW | Address of the original load |
| orig_ready | output | 1 | A slot is free for an original load |
| mem_rsp_valid | input | 1 | Memory returns data for the oldest waiting slot |
| mem_rsp_data | input | DW | Data returned by memory |
| dup_req_valid | input | 1 | Duplicate load present |
| dup_req_addr | input | AW | Address of the duplicate load |
| dup_ready | output | 1 | Oldest slot holds data and can serve a duplicate |
| dup_rsp_valid | output | 1 | Response to a duplicate accepted on the previous edge |
| dup_rsp_data | output | DW | Value recorded for that duplicate |
| fault | output | 1 | Sticky fault flag |

## Verification
The bench drives a duplicate before its memory response arrives. A design that lets it through too early would return stale slot data. It fills the queue to its limit, where an off-by-one count would either overwrite the oldest slot or refuse the last one. It then frees one slot and checks that originals flow again. A stray memory response with no waiting slot must not shift later data. A mismatched address or a duplicate on an empty queue must set the flag for good: a design that cleared it, or that dropped the data on a mismatch, would miss a check. Responses are compared in order against a scoreboard, so any break in the pairing shows up as a wrong value.

// File: rtl/dup_load_queue.sv
module dup_load_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          orig_req_valid,
  input  logic [AW-1:0] orig_req_addr,
  output logic          orig_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          dup_req_valid,
  input  logic [AW-1:0] dup_req_addr,
  output logic          dup_ready,
  output logic          dup_rsp_valid,
  output logic [DW-1:0] dup_rsp_data,
  output logic          fault
);
  // DEPTH must be a power of two: pointers wrap through their extra bit.
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [PW:0]   head, fill, tail;

  logic [PW:0] used, waiting;
  logic        orig_fire, mem_fire, dup_fire, addr_bad;

  assign used      = tail - head;
  assign waiting   = tail - fill;
  assign orig_ready = (used != FULL);
  assign dup_ready  = (fill != head);
  assign orig_fire = orig_req_valid && orig_ready;
  assign mem_fire  = mem_rsp_valid && (waiting != '0);
  assign dup_fire  = dup_req_valid && dup_ready;
  assign addr_bad  = dup_req_addr != slot_addr[head[PW-1:0]];

  always_ff @(posedge clk) begin
    if (orig_fire) slot_addr[tail[PW-1:0]] <= orig_req_addr;
    if (mem_fire)  slot_data[fill[PW-1:0]] <= mem_rsp_data;
    if (dup_fire)  dup_rsp_data <= slot_data[head[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head          <= '0;
      fill          <= '0;
      tail          <= '0;
      dup_rsp_valid <= 1'b0;
      fault         <= 1'b0;
    end else begin
      if (orig_fire) tail <= tail + 1'b1;
      if (mem_fire)  fill <= fill + 1'b1;
      if (dup_fire)  head <= head + 1'b1;
      dup_rsp_valid <= dup_fire;
      fault <= fault | (dup_fire && addr_bad) | (dup_req_valid && used == '0);
    end
  end

  p_rsp_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dup_req_valid && dup_ready |=> dup_rsp_valid);
  p_no_spurious_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dup_req_valid && dup_ready) |=> !dup_rsp_valid);
  p_mismatch_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dup_fire && addr_bad |=> fault);
  p_empty_dup_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dup_req_valid && used == '0 |=> fault && !dup_rsp_valid);
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    used == FULL && !dup_fire |=> !orig_ready);
  p_room_after_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dup_fire |=> orig_ready);
endmodule

// File: tb/test_dup_load_queue.sv
module test_dup_load_queue;
  logic        clk = 0, rst_n = 0;
  logic        orig_req_valid = 0, mem_rsp_valid = 0, dup_req_valid = 0;
  logic [31:0] orig_req_addr = 0, mem_rsp_data = 0, dup_req_addr = 0;
  logic        orig_ready, dup_ready, dup_rsp_valid, fault;
  logic [31:0] dup_rsp_data;

  int n_run = 0, n_fail = 0;
  logic [31:0] sb[$];
  logic [31:0] aq[$];
  logic [31:0] dq[$];
  logic exp_fault = 0;

  always #4 clk = ~clk;

  dup_load_queue i_dup_load_queue (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && dup_rsp_valid) begin
    if (sb.size() == 0) chk(0, "R4 unexpected response", dup_rsp_data, 0);
    else begin
      logic [31:0] e;
      e = sb.pop_front();
      chk(dup_rsp_data === e, "R3/R4 duplicate data", dup_rsp_data, e);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; orig_req_valid = 0; mem_rsp_valid = 0; dup_req_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    sb.delete(); aq.delete(); dq.delete(); exp_fault = 0;
  endtask

  task automatic orig_ld(input logic [31:0] a);
    @(negedge clk);
    orig_req_valid = 1; orig_req_addr = a;
    while (!orig_ready) @(negedge clk);
    @(negedge clk);
    orig_req_valid = 0;
    aq.push_back(a);
  endtask

  task automatic mem_rsp(input logic [31:0] d);
    @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 0;
    if (aq.size() > dq.size()) dq.push_back(d);
  endtask

  task automatic dup_ld(input logic [31:0] a);
    logic [31:0] ra;
    @(negedge clk);
    dup_req_valid = 1; dup_req_addr = a;
    while (!dup_ready) @(negedge clk);
    ra = aq.pop_front();
    sb.push_back(dq.pop_front());
    if (ra != a) exp_fault = 1;
    @(negedge clk);
    dup_req_valid = 0;
    chk(fault === exp_fault, "R6/R8 fault after duplicate", fault, exp_fault);
  endtask

  task automatic run();
    do_reset();
    // R1
    chk(orig_ready === 1, "R1 orig_ready", orig_ready, 1);
    chk(dup_ready === 0, "R1 dup_ready", dup_ready, 0);
    chk(dup_rsp_valid === 0, "R1 dup_rsp_valid", dup_rsp_valid, 0);
    chk(fault === 0, "R1 fault", fault, 0);

    // R3 R4 basic and in-order pairs
    orig_ld(32'h1000); mem_rsp(32'hA5A5_0001); dup_ld(32'h1000);
    orig_ld(32'h2000); orig_ld(32'h2004); orig_ld(32'h2008);
    mem_rsp(32'h11); mem_rsp(32'h22); mem_rsp(32'h33);
    dup_ld(32'h2000); dup_ld(32'h2004); dup_ld(32'h2008);

    // R5 duplicate waits for its memory data
    orig_ld(32'h3000);
    @(negedge clk);
    dup_req_valid = 1; dup_req_addr = 32'h3000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dup_ready === 0 && dup_rsp_valid === 0, "R5 stalled before data", dup_ready, 0);
    end
    dup_req_valid = 0;
    mem_rsp(32'hBEEF);
    chk(dup_ready === 1, "R5 ready after data", dup_ready, 1);
    dup_ld(32'h3000);

    // R2 full, R10 room after pop
    for (int i = 0; i < 8; i++) orig_ld(32'h4000 + 4*i);
    @(negedge clk);
    orig_req_valid = 1; orig_req_addr = 32'h9999;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(orig_ready === 0, "R2 full stalls originals", orig_ready, 0);
    end
    orig_req_valid = 0;
    for (int i = 0; i < 8; i++) mem_rsp(32'h500 + i);
    dup_ld(32'h4000);
    chk(orig_ready === 1, "R10 room after duplicate", orig_ready, 1);
    for (int i = 1; i < 8; i++) dup_ld(32'h4000 + 4*i);

    // R9 stray memory response ignored
    mem_rsp(32'hDEAD_DEAD);
    chk(dup_ready === 0, "R9 stray response fills nothing", dup_ready, 0);
    orig_ld(32'h6000); mem_rsp(32'h600D); dup_ld(32'h6000);
    chk(fault === 0, "R6 no fault on matching pairs", fault, 0);

    // R6 mismatch, R8 sticky
    orig_ld(32'h7000); mem_rsp(32'h7777); dup_ld(32'h7004);
    orig_ld(32'h8000); mem_rsp(32'h8888); dup_ld(32'h8000);
    repeat (3) @(negedge clk);
    chk(fault === 1, "R8 fault stays set", fault, 1);
    do_reset();
    chk(fault === 0, "R8 fault cleared by reset", fault, 0);

    // R7 duplicate on empty queue
    @(negedge clk);
    dup_req_valid = 1; dup_req_addr = 32'h1;
    @(negedge clk);
    dup_req_valid = 0;
    chk(fault === 1, "R7 empty duplicate faults", fault, 1);
    chk(dup_rsp_valid === 0, "R7 no response", dup_rsp_valid, 0);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R4 all responses seen", sb.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule